// File: doc/BRIEF.md
# Call/Return Stack Controller with Selectable Address Width

This block performs subroutine calls, subroutine returns and interrupt entry for a small processor core whose program addresses can be 16 bits wide or 24 bits wide. It owns the program counter, a two-bit address-mode register and a stack pointer of up to 10 bits. It moves program-counter bytes to and from a byte-wide stack memory, one byte per clock. For every operation it reports the number of machine cycles the core must charge for it.

The core issues a command with a two-bit opcode and a 24-bit target when `cmd_ready` is high. The controller then pushes or pops two or three bytes, depending on the address mode captured when the command was accepted. When it finishes, it updates the program counter and pulses `done` together with the cycle charge. The address mode can be rewritten at any time, but it only affects commands accepted after the write. An extended-stack enable picks either an 8-bit wrapping pointer or a 10-bit wrapping pointer.

Top module: `callstk_ctrl`

## Requirements
- R1: During reset, the mode register loads 2'b10 if `rom_en` is high and 2'b01 if it is low. The program counter resets to 0, the stack pointer to 10'h007, `cmd_ready` is high and `done` is low.
- R2: Mode decode is 2'b00 for paged 24-bit, 2'b01 for 16-bit, and 2'b10 or 2'b11 for contiguous 24-bit. A call or return moves 2 bytes in 16-bit mode and 3 bytes in both 24-bit modes.
- R3: A push first increments the pointer and then writes the byte. The least significant program-counter byte goes to the first location and higher bytes follow. The pointer ends up advanced by the byte count.
- R4: A pop reads the location the pointer names and then decrements the pointer, so the most significant saved byte comes back first. RET (2'b01) and RETI (2'b10) behave the same way. The pointer ends up lowered by the byte count.
- R5: In 16-bit mode the upper program-counter byte becomes zero after any call, interrupt entry or return, whatever the target or stack contents.
- R6: Interrupt entry (2'b11) loads the program counter with `{8'h00, cmd_tgt[15:0]}` in paged and 16-bit modes, and with the full `cmd_tgt` in contiguous mode. A call (2'b00) loads the full `cmd_tgt` in both 24-bit modes.
- R7: The reported charge is 3 for a call, 3 for RET and RETI, and 5 for interrupt entry, plus 1 in paged mode. It appears on `done_cyc` while the one-cycle `done` pulse is high.
- R8: With `xstk_en` low, only pointer bits 7:0 change and wrap modulo 256, bits 9:8 are kept, and the memory address is `{2'b00, sp[7:0]}`. With `xstk_en` high, the pointer wraps modulo 1024 and addresses memory directly.
- R9: A command uses the mode held when it was accepted. A mode write in the same cycle as acceptance, or during the operation, changes only later commands, while `mode_out` shows the new value at once.
- R10: `sp_ld` loads the pointer only when the controller is idle and no command is accepted in the same cycle. Otherwise it is ignored.
- R11: The stack port transfers at most one byte per cycle and never asserts `stk_we` and `stk_re` together. Read data is expected on `stk_rdata` one cycle after `stk_re`.
- R12: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low until the operation ends, and `done` is only ever high while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_en | input | 1 | Selects the mode loaded during reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | New mode value |
| mode_out | output | 2 | Current mode register |
| xstk_en | input | 1 | Enables 10-bit stack pointer wrapping |
| sp_ld | input | 1 | Stack pointer load strobe |
| sp_ld_val | input | 10 | Stack pointer load value |
| sp_out | output | 10 | Current stack pointer |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 call, 01 return, 10 interrupt return, 11 interrupt entry |
| cmd_tgt | input | 24 | Call target or interrupt vector |
| cmd_ready | output | 1 | Controller idle, command can be accepted |
| pc_out | output | 24 | Program counter |
| done | output | 1 | One-cycle completion pulse |
| done_cyc | output | 4 | Machine-cycle charge of the finished operation |
| stk_we | output | 1 | Stack memory write |
| stk_re | output | 1 | Stack memory read |
| stk_addr | output | 10 | Stack memory address |
| stk_wdata | output | 8 | Stack write byte |
| stk_rdata | input | 8 | Stack read byte, valid one cycle after the read |

## Verification
Two kinds of collision matter here. The first is a mode write landing in the same cycle a command is accepted, or while one is in progress. The second is a pointer load arriving together with a command, or during one. The bench drives both strobes on the exact acceptance edge and again on the first busy edge. It judges the result by the bytes moved, the final pointer and the reported cycle charge, which must all follow the mode captured at acceptance. It also checks that `mode_out` already shows the new value. A full sweep over every mode, both stack widths and pointer starts that cross the 8-bit and 10-bit wrap points checks pushes, pops and vectors against arithmetic models.

// File: rtl/callstk_pkg.sv
// Shared types for the call/return stack controller.
// Assumes a byte-wide stack memory and at most three program-counter bytes.
package callstk_pkg;

    // Command opcodes as seen on cmd_op.
    typedef enum logic [1:0] {
        OP_CALL = 2'd0,
        OP_RET  = 2'd1,
        OP_RETI = 2'd2,
        OP_INT  = 2'd3
    } op_e;

    // Address-mode encodings; 2'b11 decodes like 2'b10.
    localparam logic [1:0] MD_PAGED = 2'b00;
    localparam logic [1:0] MD_B16   = 2'b01;
    localparam logic [1:0] MD_CONT  = 2'b10;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_POPL
    } st_e;

endpackage

// File: rtl/callstk_mode_dec.sv
// Mode decoder: turns the two-bit address mode and the opcode into the
// byte count, the paged/16-bit flags and the machine-cycle charge.
// Purely combinational; assumes the charge fits in CYC_W bits.
module callstk_mode_dec
    import callstk_pkg::*;
#(
    parameter int CYC_W    = 4,
    parameter int CYC_CALL = 3,
    parameter int CYC_RET  = 3,
    parameter int CYC_INT  = 5
) (
    input  logic [1:0]       mode,
    input  logic [1:0]       op,
    output logic             three_b,
    output logic             paged,
    output logic             low64k,
    output logic [CYC_W-1:0] cyc
);

    logic [CYC_W-1:0] base;

    // Decode mode flags and pick the base charge for the opcode.
    always_comb begin
        paged   = (mode == MD_PAGED);
        low64k  = (mode == MD_B16);
        three_b = !low64k;
        unique case (op_e'(op))
            OP_CALL: base = CYC_W'(CYC_CALL);
            OP_RET,
            OP_RETI: base = CYC_W'(CYC_RET);
            default: base = CYC_W'(CYC_INT);
        endcase
        cyc = base + CYC_W'(paged);
    end

endmodule

// File: rtl/callstk_sp.sv
// Stack pointer register with a selectable wrap width.
// When wide is low only the low LO_W bits count and wrap; the upper bits
// are held and the memory address drops them. Load has priority over
// increment, and increment over decrement.
module callstk_sp #(
    parameter int SP_W   = 10,
    parameter int LO_W   = 8,
    parameter int SP_RST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            inc,
    input  logic            dec,
    input  logic            ld,
    input  logic [SP_W-1:0] ld_val,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] addr_cur,
    output logic [SP_W-1:0] addr_inc
);

    localparam int HI_W = SP_W - LO_W;

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] nxt_up;
    logic [SP_W-1:0] nxt_dn;

    // Wrap-aware neighbours of the current pointer.
    always_comb begin
        if (wide) begin
            nxt_up = sp_q + SP_W'(1);
            nxt_dn = sp_q - SP_W'(1);
        end else begin
            nxt_up = {sp_q[SP_W-1:LO_W], sp_q[LO_W-1:0] + LO_W'(1)};
            nxt_dn = {sp_q[SP_W-1:LO_W], sp_q[LO_W-1:0] - LO_W'(1)};
        end
    end

    // Map pointer values onto memory addresses for the selected width.
    always_comb begin
        if (wide) begin
            addr_cur = sp_q;
            addr_inc = nxt_up;
        end else begin
            addr_cur = {{HI_W{1'b0}}, sp_q[LO_W-1:0]};
            addr_inc = {{HI_W{1'b0}}, nxt_up[LO_W-1:0]};
        end
    end

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp_q <= SP_W'(SP_RST);
        else if (ld)  sp_q <= ld_val;
        else if (inc) sp_q <= nxt_up;
        else if (dec) sp_q <= nxt_dn;
    end

    assign sp = sp_q;

endmodule

// File: rtl/callstk_seq.sv
// Push/pop sequencer. It owns the program counter and moves its bytes to
// or from a byte-wide stack memory whose read data arrives one cycle
// after the read strobe. Mode-dependent settings are captured when a
// command is accepted and held until the operation completes.
module callstk_seq
    import callstk_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NB_MAX = 3,
    parameter int CYC_W  = 4,
    localparam int PC_W  = BYTE_W * NB_MAX,
    localparam int CNT_W = $clog2(NB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PC_W-1:0]   cmd_tgt,
    output logic              cmd_ready,
    input  logic              three_b,
    input  logic              paged,
    input  logic              low64k,
    input  logic [CYC_W-1:0]  cyc_in,
    input  logic              wide_in,
    output logic              op_wide,
    output logic              stk_we,
    output logic              stk_re,
    output logic [BYTE_W-1:0] stk_wdata,
    input  logic [BYTE_W-1:0] stk_rdata,
    output logic [PC_W-1:0]   pc,
    output logic              done,
    output logic [CYC_W-1:0]  done_cyc
);

    localparam int LOW_W = PC_W - BYTE_W;

    st_e              st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  sh_q;
    logic [PC_W-1:0]  tgt_q;
    logic [PC_W-1:0]  pc_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CYC_W-1:0] done_cyc_q;
    logic             low64k_q;
    logic             wide_q;
    logic             rd_pend_q;
    logic             done_q;

    logic             accept;
    logic             is_push;
    logic             zero_up;
    logic [CNT_W-1:0] nb;
    logic [PC_W-1:0]  tgt_eff;
    logic [PC_W-1:0]  popped;

    // Acceptance, per-command settings and the popped word.
    always_comb begin
        accept  = (st_q == ST_IDLE) && cmd_valid;
        is_push = (op_e'(cmd_op) == OP_CALL) || (op_e'(cmd_op) == OP_INT);
        zero_up = low64k || ((op_e'(cmd_op) == OP_INT) && paged);
        nb      = three_b ? CNT_W'(NB_MAX) : CNT_W'(NB_MAX - 1);
        tgt_eff = zero_up ? {{BYTE_W{1'b0}}, cmd_tgt[LOW_W-1:0]} : cmd_tgt;
        popped  = {sh_q[LOW_W-1:0], stk_rdata};
    end

    // Stack port strobes follow the state directly.
    always_comb begin
        cmd_ready = (st_q == ST_IDLE);
        stk_we    = (st_q == ST_PUSH);
        stk_re    = (st_q == ST_POP);
        stk_wdata = sh_q[BYTE_W-1:0];
    end

    // Remember that read data is due on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_pend_q <= 1'b0;
        else        rd_pend_q <= stk_re;
    end

    // Main sequencer: start, shift bytes out or in, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            tgt_q      <= '0;
            pc_q       <= '0;
            cyc_q      <= '0;
            done_cyc_q <= '0;
            low64k_q   <= 1'b0;
            wide_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        cyc_q    <= cyc_in;
                        low64k_q <= low64k;
                        wide_q   <= wide_in;
                        cnt_q    <= nb;
                        tgt_q    <= tgt_eff;
                        if (is_push) begin
                            sh_q <= pc_q;
                            st_q <= ST_PUSH;
                        end else begin
                            sh_q <= '0;
                            st_q <= ST_POP;
                        end
                    end
                end
                ST_PUSH: begin
                    sh_q  <= sh_q >> BYTE_W;
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        st_q       <= ST_IDLE;
                        pc_q       <= tgt_q;
                        done_q     <= 1'b1;
                        done_cyc_q <= cyc_q;
                    end
                end
                ST_POP: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (rd_pend_q) sh_q <= popped;
                    if (cnt_q == CNT_W'(1)) st_q <= ST_POPL;
                end
                default: begin
                    st_q       <= ST_IDLE;
                    pc_q       <= low64k_q ? {{BYTE_W{1'b0}}, popped[LOW_W-1:0]} : popped;
                    done_q     <= 1'b1;
                    done_cyc_q <= cyc_q;
                end
            endcase
        end
    end

    assign op_wide  = wide_q;
    assign pc       = pc_q;
    assign done     = done_q;
    assign done_cyc = done_cyc_q;

endmodule

// File: rtl/callstk_ctrl.sv
// Top of the call/return stack controller. It holds the address-mode
// register, decodes it, and joins the sequencer to the stack pointer.
// Assumes a stack memory with one-cycle read latency.
module callstk_ctrl #(
    parameter int BYTE_W   = 8,
    parameter int NB_MAX   = 3,
    parameter int SP_W     = 10,
    parameter int SP_LO_W  = 8,
    parameter int SP_RST   = 7,
    parameter int CYC_W    = 4,
    parameter int CYC_CALL = 3,
    parameter int CYC_RET  = 3,
    parameter int CYC_INT  = 5,
    localparam int PC_W    = BYTE_W * NB_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rom_en,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_out,
    input  logic              xstk_en,
    input  logic              sp_ld,
    input  logic [SP_W-1:0]   sp_ld_val,
    output logic [SP_W-1:0]   sp_out,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PC_W-1:0]   cmd_tgt,
    output logic              cmd_ready,
    output logic [PC_W-1:0]   pc_out,
    output logic              done,
    output logic [CYC_W-1:0]  done_cyc,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [BYTE_W-1:0] stk_wdata,
    input  logic [BYTE_W-1:0] stk_rdata
);

    import callstk_pkg::*;

    logic [1:0]       mode_q;
    logic             three_b;
    logic             paged;
    logic             low64k;
    logic [CYC_W-1:0] cyc;
    logic             op_wide;
    logic             sp_ld_eff;
    logic [SP_W-1:0]  addr_cur;
    logic [SP_W-1:0]  addr_inc;

    // Mode register: reset default chosen by rom_en, writable any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= rom_en ? MD_CONT : MD_B16;
        else if (mode_we) mode_q <= mode_wdata;
    end

    // Pointer load only in a quiet idle cycle.
    always_comb sp_ld_eff = sp_ld && cmd_ready && !cmd_valid;

    // Stack address: next slot while pushing, current slot otherwise.
    always_comb stk_addr = stk_we ? addr_inc : addr_cur;

    callstk_mode_dec #(
        .CYC_W   (CYC_W),
        .CYC_CALL(CYC_CALL),
        .CYC_RET (CYC_RET),
        .CYC_INT (CYC_INT)
    ) u_dec (
        .mode   (mode_q),
        .op     (cmd_op),
        .three_b(three_b),
        .paged  (paged),
        .low64k (low64k),
        .cyc    (cyc)
    );

    callstk_seq #(
        .BYTE_W(BYTE_W),
        .NB_MAX(NB_MAX),
        .CYC_W (CYC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_tgt  (cmd_tgt),
        .cmd_ready(cmd_ready),
        .three_b  (three_b),
        .paged    (paged),
        .low64k   (low64k),
        .cyc_in   (cyc),
        .wide_in  (xstk_en),
        .op_wide  (op_wide),
        .stk_we   (stk_we),
        .stk_re   (stk_re),
        .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata),
        .pc       (pc_out),
        .done     (done),
        .done_cyc (done_cyc)
    );

    callstk_sp #(
        .SP_W  (SP_W),
        .LO_W  (SP_LO_W),
        .SP_RST(SP_RST)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (op_wide),
        .inc     (stk_we),
        .dec     (stk_re),
        .ld      (sp_ld_eff),
        .ld_val  (sp_ld_val),
        .sp      (sp_out),
        .addr_cur(addr_cur),
        .addr_inc(addr_inc)
    );

    assign mode_out = mode_q;

endmodule

// File: rtl/callstk_ctrl_chk.sv
// Property checker for the call/return stack controller, attached by bind.
// Observes ports only; assumes the default 10-bit pointer with 8 low bits.
module callstk_ctrl_chk #(
    parameter int SP_W = 10,
    parameter int LO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            sp_ld,
    input logic            stk_we,
    input logic            stk_re,
    input logic [SP_W-1:0] stk_addr,
    input logic [SP_W-1:0] sp_out,
    input logic            done
);

    // R11: never read and write the stack in one cycle.
    a_r11_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re));

    // R3: the written slot is where the pointer lands afterwards.
    a_r3_push_preinc: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp_out[LO_W-1:0] == $past(stk_addr[LO_W-1:0])));

    // R4: the read slot is one above where the pointer lands afterwards.
    a_r4_pop_postdec: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re |=> (sp_out[LO_W-1:0] == $past(stk_addr[LO_W-1:0]) - LO_W'(1)));

    // R10: an idle cycle without command or load leaves the pointer alone.
    a_r10_idle_sp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid && !sp_ld) |=> $stable(sp_out));

    // R7: completion is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: completion only shows while the controller is idle.
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    // R12: a busy controller never starts moving bytes without having accepted.
    a_r12_port_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we || stk_re) |-> !cmd_ready);

endmodule

bind callstk_ctrl callstk_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .sp_ld    (sp_ld),
    .stk_we   (stk_we),
    .stk_re   (stk_re),
    .stk_addr (stk_addr),
    .sp_out   (sp_out),
    .done     (done)
);

// File: tb/callstk_ctrl_test.sv
`timescale 1ns/1ps
// Sweep bench for callstk_ctrl: every mode, both stack widths and three
// pointer starts, plus same-cycle collisions of mode writes and pointer
// loads with commands. Expected values come from arithmetic models here.
module callstk_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rom_en = 1'b1;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = 2'b00;
    logic [1:0]  mode_out;
    logic        xstk_en = 1'b0;
    logic        sp_ld = 1'b0;
    logic [9:0]  sp_ld_val = '0;
    logic [9:0]  sp_out;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [23:0] cmd_tgt = '0;
    logic        cmd_ready;
    logic [23:0] pc_out;
    logic        done;
    logic [3:0]  done_cyc;
    logic        stk_we;
    logic        stk_re;
    logic [9:0]  stk_addr;
    logic [7:0]  stk_wdata;
    logic [7:0]  stk_rdata;

    logic [7:0]  mem [0:1023];

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Stack memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
        if (stk_re) stk_rdata <= mem[stk_addr];
    end

    callstk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rom_en(rom_en),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_out(mode_out),
        .xstk_en(xstk_en), .sp_ld(sp_ld), .sp_ld_val(sp_ld_val), .sp_out(sp_out),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_tgt(cmd_tgt),
        .cmd_ready(cmd_ready), .pc_out(pc_out), .done(done), .done_cyc(done_cyc),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] sp_mv(input logic [9:0] v, input int n, input bit w);
        logic [9:0] f;
        logic [7:0] lo;
        f  = v + 10'(n);
        lo = v[7:0] + 8'(n);
        return w ? f : {v[9:8], lo};
    endfunction

    function automatic logic [9:0] addr_of(input logic [9:0] v, input bit w);
        return w ? v : {2'b00, v[7:0]};
    endfunction

    // Read back the bytes pushed above base, assembled high byte first.
    function automatic logic [23:0] pushed(input logic [9:0] base, input int nb, input bit w);
        logic [23:0] r;
        r = '0;
        for (int j = nb - 1; j >= 0; j--)
            r = {r[15:0], mem[addr_of(sp_mv(base, j + 1, w), w)]};
        return r;
    endfunction

    // Issue one command, with optional strobes at acceptance or one cycle later.
    task automatic run_cmd(input logic [1:0] op, input logic [23:0] tgt,
                           input bit mw_now, input bit mw_late, input logic [1:0] mw_val,
                           input bit ld_now, input bit ld_late, input logic [9:0] ld_val,
                           output logic [3:0] cyc);
        int guard;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_tgt = tgt;
        mode_we = mw_now; mode_wdata = mw_val;
        sp_ld = ld_now; sp_ld_val = ld_val;
        @(negedge clk);
        cmd_valid = 1'b0;
        mode_we = mw_late; sp_ld = ld_late;
        @(negedge clk);
        mode_we = 1'b0; sp_ld = 1'b0;
        guard = 0;
        while (!done && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R12 actual=no-done expected=done");
        end
        cyc = done_cyc;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic load_sp(input logic [9:0] v);
        @(negedge clk); sp_ld = 1'b1; sp_ld_val = v;
        @(negedge clk); sp_ld = 1'b0;
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] exp_pc;
        logic [23:0] pc_a;
        logic [3:0]  cyc;
        int          k;

        // R1: reset with rom_en high.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", 32'(mode_out), 32'h2);
        chk("R1 pc", 32'(pc_out), 32'h0);
        chk("R1 sp", 32'(sp_out), 32'h007);
        chk("R1 ready", 32'(cmd_ready), 32'h1);
        chk("R1 done", 32'(done), 32'h0);
        exp_pc = '0;
        k = 0;

        // Sweep: R2 R3 R4 R5 R6 R7 R8.
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 3; s++) begin
                    logic [9:0]  sp0;
                    logic [23:0] ta;
                    logic [23:0] tb;
                    logic [23:0] msk;
                    int          nb;
                    int          ex;
                    sp0 = (s == 0) ? 10'h007 : (s == 1) ? 10'h0FD : 10'h3FE;
                    ta  = {8'hC3 - 8'(k), 8'h5A + 8'(k), 8'h69 ^ 8'(k)};
                    tb  = {8'h7E, 8'h01, 8'h0B + 8'(k)};
                    nb  = (m == 1) ? 2 : 3;
                    ex  = (m == 0) ? 1 : 0;
                    msk = (nb == 2) ? 24'h00FFFF : 24'hFFFFFF;
                    k++;
                    set_mode(2'(m));
                    xstk_en = w[0];
                    load_sp(sp0);
                    chk("R10 load", 32'(sp_out), 32'(sp0));

                    // Call.
                    run_cmd(2'd0, ta, 0, 0, 2'd0, 0, 0, 10'd0, cyc);
                    pc_a = (m == 1) ? {8'h00, ta[15:0]} : ta;
                    chk("R5 R6 call pc", 32'(pc_out), 32'(pc_a));
                    chk("R3 R8 call sp", 32'(sp_out), 32'(sp_mv(sp0, nb, w[0])));
                    chk("R2 R3 call bytes", 32'(pushed(sp0, nb, w[0])), 32'(exp_pc & msk));
                    chk("R7 call cyc", 32'(cyc), 32'(3 + ex));

                    // Interrupt entry.
                    run_cmd(2'd3, tb, 0, 0, 2'd0, 0, 0, 10'd0, cyc);
                    chk("R6 int pc", 32'(pc_out), (m >= 2) ? 32'(tb) : 32'({8'h00, tb[15:0]}));
                    chk("R3 R8 int sp", 32'(sp_out), 32'(sp_mv(sp0, 2 * nb, w[0])));
                    chk("R3 int bytes", 32'(pushed(sp_mv(sp0, nb, w[0]), nb, w[0])), 32'(pc_a & msk));
                    chk("R7 int cyc", 32'(cyc), 32'(5 + ex));

                    // Interrupt return.
                    run_cmd(2'd2, 24'h0, 0, 0, 2'd0, 0, 0, 10'd0, cyc);
                    chk("R4 reti pc", 32'(pc_out), 32'(pc_a & msk));
                    chk("R4 R8 reti sp", 32'(sp_out), 32'(sp_mv(sp0, nb, w[0])));
                    chk("R7 reti cyc", 32'(cyc), 32'(3 + ex));

                    // Subroutine return.
                    run_cmd(2'd1, 24'h0, 0, 0, 2'd0, 0, 0, 10'd0, cyc);
                    chk("R4 R5 ret pc", 32'(pc_out), 32'(exp_pc & msk));
                    chk("R4 R8 ret sp", 32'(sp_out), 32'(sp0));
                    chk("R7 ret cyc", 32'(cyc), 32'(3 + ex));
                    exp_pc = exp_pc & msk;
                end
            end
        end

        // R9: mode write on the acceptance edge does not affect that call.
        set_mode(2'b01);
        xstk_en = 1'b1;
        load_sp(10'h100);
        run_cmd(2'd0, 24'h123456, 1, 0, 2'b00, 0, 0, 10'd0, cyc);
        chk("R9 same-cycle cyc", 32'(cyc), 32'd3);
        chk("R9 same-cycle sp", 32'(sp_out), 32'h102);
        chk("R9 same-cycle pc", 32'(pc_out), 32'h003456);
        chk("R9 mode_out", 32'(mode_out), 32'h0);

        // R9 R10: mode write and pointer load while busy are respectively deferred and dropped.
        load_sp(10'h100);
        run_cmd(2'd0, 24'h654321, 0, 1, 2'b01, 0, 1, 10'h2AA, cyc);
        chk("R9 busy cyc", 32'(cyc), 32'd4);
        chk("R10 busy sp", 32'(sp_out), 32'h103);
        chk("R9 busy pc", 32'(pc_out), 32'h654321);
        chk("R9 busy mode_out", 32'(mode_out), 32'h1);

        // R10: pointer load on the acceptance edge is dropped; 16-bit pop of two bytes.
        run_cmd(2'd1, 24'h0, 0, 0, 2'b00, 1, 0, 10'h055, cyc);
        chk("R10 same-cycle sp", 32'(sp_out), 32'h101);
        chk("R4 R5 two-byte pop pc", 32'(pc_out), 32'h000034);
        chk("R7 16-bit ret cyc", 32'(cyc), 32'd3);

        // R1: reset with rom_en low.
        @(negedge clk);
        rst_n = 1'b0; rom_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode low rom", 32'(mode_out), 32'h1);
        chk("R1 sp low rom", 32'(sp_out), 32'h007);
        chk("R1 pc low rom", 32'(pc_out), 32'h0);
        chk("R1 ready low rom", 32'(cmd_ready), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule